// File: doc/BRIEF.md
# Event-Selectable Performance Counter

This block counts one chosen kind of pipeline event. A 19-bit event bus comes in from the processor pipeline, and every bus bit reports one condition in the current cycle. Software writes an event number into a selector register. Each cycle the block turns that number into the bus bit, or the pair of bus bits, that the event uses. It then adds 0, 1 or 2 to a 32-bit count.

Two events can happen twice in one cycle, so they use two bus bits and can add two in a single step. Some event numbers and one bus bit are unused. A selector holding an unused number leaves the count unchanged. A small register write port holds the count enable, the selector and a preload value, and it also accepts clear pulses for the count and for the overflow flag. The count is a plain output. A sticky overflow flag reports every wrap of the count.

Top module: `evsel_perf_counter`

## Requirements
- R1: After synchronous reset (`rst_i` high) the count is 0, the overflow flag is 0, counting is disabled and the selector is 0. No bus activity changes the count until software sets the enable bit.
- R2: Single-bit events add 1 in a cycle where their bus bit is high. The mapping is code 0x0–0x5 to bits 0–5, code 0x6 to bit 7, code 0x9–0xC to bits 10–13, and code 0xF–0x11 to bits 16–18. Bus bit 6 is never counted under any code.
- R3: Code 0x7 adds 2 in a cycle where bus bit 9 is high. Otherwise it adds 1 when bus bit 8 is high.
- R4: Code 0xD adds 2 in a cycle where bus bit 15 is high. Otherwise it adds 1 when bus bit 14 is high.
- R5: Level-type events (codes 0x1, 0x2 and 0x11) add 1 in every clock cycle in which their bit is high.
- R6: Codes 0x8, 0xE and 0x12–0x1F are reserved. While one of them is selected, the count does not change, whatever the bus carries.
- R7: With the enable bit (bit 0 of the control register, address 0) at 0, the count holds.
- R8: Writing 1 to bit 1 of the control register makes the count 0 in the next cycle. This clear takes priority over an increment in the same cycle.
- R9: A write to the selector (address 1, bits [4:0]) takes effect from the following cycle. Bus activity in the write cycle is counted under the old code.
- R10: A write to the preload register (address 2, 32 bits) sets the count to the written value in the next cycle. An event in the same cycle is dropped.
- R11: The count wraps modulo 2^32, including +2 steps from 0xFFFFFFFE or 0xFFFFFFFF. Each wrap sets the sticky overflow flag. The flag stays set until a write of 1 to bit 2 of the control register clears it. A preload never sets the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| evt_bus_i | input | 19 | Per-cycle event bits from the pipeline |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address: 0 control, 1 selector, 2 preload |
| wr_data_i | input | 32 | Register write data |
| count_o | output | 32 | Current count |
| ovf_o | output | 1 | Sticky overflow flag |

## Verification
Several behaviours are checked by the assertions on every cycle. The count holds while disabled or while a reserved code is selected. A clear or a preload lands one cycle after its write. A +2 step under code 0x7 adds exactly two. A set overflow flag stays set until it is cleared. Other behaviours can only be shown by the bench scenarios. These are the decode of each event code to its bus position, including the unused bit 6 and the reserved codes. Also covered there are the old-code counting in the selector write cycle, level events held over many cycles, and the exact wrap results from 0xFFFFFFFE and 0xFFFFFFFF.

// File: rtl/perfcnt_pkg.sv
package perfcnt_pkg;

    localparam int unsigned EVT_BUS_W = 19;

    typedef enum logic [1:0] {
        PC_REG_CTRL = 2'd0,
        PC_REG_SEL  = 2'd1,
        PC_REG_LOAD = 2'd2,
        PC_REG_NONE = 2'd3
    } pc_reg_e;

    localparam int unsigned PC_CTL_EN    = 0;
    localparam int unsigned PC_CTL_CLR   = 1;
    localparam int unsigned PC_CTL_OVCLR = 2;

    // Increment contributed this cycle by event code 'code' on bus 'bus'.
    function automatic logic [1:0] pc_code_inc(input int unsigned code,
                                               input logic [EVT_BUS_W-1:0] bus);
        logic [1:0] r;
        r = 2'd0;
        case (code)
            0:  r = {1'b0, bus[0]};
            1:  r = {1'b0, bus[1]};
            2:  r = {1'b0, bus[2]};
            3:  r = {1'b0, bus[3]};
            4:  r = {1'b0, bus[4]};
            5:  r = {1'b0, bus[5]};
            6:  r = {1'b0, bus[7]};
            7:  r = bus[9] ? 2'd2 : {1'b0, bus[8]};
            9:  r = {1'b0, bus[10]};
            10: r = {1'b0, bus[11]};
            11: r = {1'b0, bus[12]};
            12: r = {1'b0, bus[13]};
            13: r = bus[15] ? 2'd2 : {1'b0, bus[14]};
            15: r = {1'b0, bus[16]};
            16: r = {1'b0, bus[17]};
            17: r = {1'b0, bus[18]};
            default: r = 2'd0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pc_evt_decode.sv
module pc_evt_decode
    import perfcnt_pkg::*;
#(
    parameter int unsigned SEL_W = 5
) (
    input  logic [SEL_W-1:0]     sel_i,
    input  logic [EVT_BUS_W-1:0] bus_i,
    output logic [1:0]           inc_o
);
    localparam int unsigned NCODES = 1 << SEL_W;

    logic [1:0] inc_tab [NCODES];

    for (genvar c = 0; c < NCODES; c++) begin : g_code
        assign inc_tab[c] = pc_code_inc(c, bus_i);
    end

    assign inc_o = inc_tab[sel_i];
endmodule

// File: rtl/pc_ctrl_regs.sv
module pc_ctrl_regs
    import perfcnt_pkg::*;
#(
    parameter int unsigned SEL_W  = 5,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              wr_en_i,
    input  logic [1:0]        wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic              en_o,
    output logic [SEL_W-1:0]  sel_o,
    output logic              clr_cnt_o,
    output logic              clr_ovf_o,
    output logic              load_o,
    output logic [DATA_W-1:0] load_val_o
);
    typedef struct packed {
        logic             en;
        logic [SEL_W-1:0] sel;
    } regs_t;

    regs_t st_d, st_q;
    logic  wr_ctrl, wr_sel, wr_load;

    always_comb begin
        wr_ctrl = wr_en_i && (pc_reg_e'(wr_addr_i) == PC_REG_CTRL);
        wr_sel  = wr_en_i && (pc_reg_e'(wr_addr_i) == PC_REG_SEL);
        wr_load = wr_en_i && (pc_reg_e'(wr_addr_i) == PC_REG_LOAD);
        st_d    = st_q;
        if (wr_ctrl) st_d.en  = wr_data_i[PC_CTL_EN];
        if (wr_sel)  st_d.sel = wr_data_i[SEL_W-1:0];
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= '0;
        else       st_q <= st_d;
    end

    assign en_o       = st_q.en;
    assign sel_o      = st_q.sel;
    assign clr_cnt_o  = wr_ctrl && wr_data_i[PC_CTL_CLR];
    assign clr_ovf_o  = wr_ctrl && wr_data_i[PC_CTL_OVCLR];
    assign load_o     = wr_load;
    assign load_val_o = wr_data_i;
endmodule

// File: rtl/pc_count_core.sv
module pc_count_core #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             en_i,
    input  logic [1:0]       inc_i,
    input  logic             clr_cnt_i,
    input  logic             clr_ovf_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic [CNT_W-1:0] count_o,
    output logic             ovf_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             ovf;
    } core_t;

    core_t          st_d, st_q;
    logic [CNT_W:0] sum;
    logic           step;

    always_comb begin
        st_d = st_q;
        sum  = {1'b0, st_q.cnt} + {{(CNT_W-1){1'b0}}, inc_i};
        step = en_i && !clr_cnt_i && !load_i;
        if (clr_ovf_i) st_d.ovf = 1'b0;
        if (clr_cnt_i) begin
            st_d.cnt = '0;
        end else if (load_i) begin
            st_d.cnt = load_val_i;
        end else if (en_i) begin
            st_d.cnt = sum[CNT_W-1:0];
        end
        if (step && sum[CNT_W]) st_d.ovf = 1'b1;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= '0;
        else       st_q <= st_d;
    end

    assign count_o = st_q.cnt;
    assign ovf_o   = st_q.ovf;
endmodule

// File: rtl/evsel_perf_counter.sv
module evsel_perf_counter
    import perfcnt_pkg::*;
#(
    parameter int unsigned CNT_W = 32,
    parameter int unsigned SEL_W = 5
) (
    input  logic                 clk_i,
    input  logic                 rst_i,
    input  logic [EVT_BUS_W-1:0] evt_bus_i,
    input  logic                 wr_en_i,
    input  logic [1:0]           wr_addr_i,
    input  logic [CNT_W-1:0]     wr_data_i,
    output logic [CNT_W-1:0]     count_o,
    output logic                 ovf_o
);
    logic             en_q;
    logic [SEL_W-1:0] sel_q;
    logic             clr_cnt, clr_ovf, load;
    logic [CNT_W-1:0] load_val;
    logic [1:0]       inc;

    pc_ctrl_regs #(.SEL_W(SEL_W), .DATA_W(CNT_W)) u_regs (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .wr_en_i    (wr_en_i),
        .wr_addr_i  (wr_addr_i),
        .wr_data_i  (wr_data_i),
        .en_o       (en_q),
        .sel_o      (sel_q),
        .clr_cnt_o  (clr_cnt),
        .clr_ovf_o  (clr_ovf),
        .load_o     (load),
        .load_val_o (load_val)
    );

    pc_evt_decode #(.SEL_W(SEL_W)) u_dec (
        .sel_i (sel_q),
        .bus_i (evt_bus_i),
        .inc_o (inc)
    );

    pc_count_core #(.CNT_W(CNT_W)) u_core (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .en_i       (en_q),
        .inc_i      (inc),
        .clr_cnt_i  (clr_cnt),
        .clr_ovf_i  (clr_ovf),
        .load_i     (load),
        .load_val_i (load_val),
        .count_o    (count_o),
        .ovf_o      (ovf_o)
    );
endmodule

// File: rtl/evsel_perf_counter_chk.sv
module evsel_perf_counter_chk #(
    parameter int unsigned CNT_W = 32,
    parameter int unsigned SEL_W = 5
) (
    input logic             clk_i,
    input logic             rst_i,
    input logic [18:0]      evt_bus_i,
    input logic             wr_en_i,
    input logic [1:0]       wr_addr_i,
    input logic [CNT_W-1:0] wr_data_i,
    input logic [CNT_W-1:0] count_o,
    input logic             ovf_o,
    input logic             en_q,
    input logic [SEL_W-1:0] sel_q
);
    logic reserved_sel;
    assign reserved_sel = (sel_q == 5'd8) || (sel_q == 5'd14) || (sel_q > 5'd17);

    // R1
    reset_zero_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(rst_i) |-> (count_o == '0 && !ovf_o));

    // R6
    reserved_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (reserved_sel && !wr_en_i) |=> $stable(count_o));

    // R7
    disabled_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (!en_q && !wr_en_i) |=> $stable(count_o));

    // R8
    clear_count_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (wr_en_i && wr_addr_i == 2'd0 && wr_data_i[1]) |=> (count_o == '0));

    // R10
    preload_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (wr_en_i && wr_addr_i == 2'd2) |=> (count_o == $past(wr_data_i)));

    // R3
    double_step_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (en_q && !wr_en_i && sel_q == 5'd7 && evt_bus_i[9])
        |=> (count_o == $past(count_o) + 2));

    // R11
    ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (ovf_o && !(wr_en_i && wr_addr_i == 2'd0 && wr_data_i[2])) |=> ovf_o);
endmodule

bind evsel_perf_counter evsel_perf_counter_chk #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_chk (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .evt_bus_i (evt_bus_i),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .count_o   (count_o),
    .ovf_o     (ovf_o),
    .en_q      (en_q),
    .sel_q     (sel_q)
);

// File: tb/evsel_perf_counter_tb_top.sv
module evsel_perf_counter_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [18:0] bus = '0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] count;
    logic        ovf;
    int          n_chk = 0;
    int          n_bad = 0;

    always #5 clk = ~clk;

    evsel_perf_counter dut_i (
        .clk_i(clk), .rst_i(rst), .evt_bus_i(bus), .wr_en_i(wr_en),
        .wr_addr_i(wr_addr), .wr_data_i(wr_data), .count_o(count), .ovf_o(ovf)
    );

    // {code[4:0], bus[18:0], expected increment[1:0]}
    localparam int NV = 19;
    localparam logic [25:0] VEC [NV] = '{
        {5'h00, 19'h00001, 2'd1}, {5'h01, 19'h00002, 2'd1},
        {5'h03, 19'h00008, 2'd1}, {5'h05, 19'h00020, 2'd1},
        {5'h06, 19'h00080, 2'd1}, {5'h06, 19'h00040, 2'd0},
        {5'h05, 19'h00040, 2'd0}, {5'h07, 19'h00100, 2'd1},
        {5'h07, 19'h00300, 2'd2}, {5'h09, 19'h00400, 2'd1},
        {5'h0C, 19'h02000, 2'd1}, {5'h0D, 19'h04000, 2'd1},
        {5'h0D, 19'h0C000, 2'd2}, {5'h0F, 19'h10000, 2'd1},
        {5'h11, 19'h40000, 2'd1}, {5'h10, 19'h5FFFF, 2'd0},
        {5'h08, 19'h7FFFF, 2'd0}, {5'h0E, 19'h7FFFF, 2'd0},
        {5'h1F, 19'h7FFFF, 2'd0}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    // drive at negedge, write lands at the next posedge
    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 count after reset", count, 32'd0);
        check("R1 ovf after reset", {31'd0, ovf}, 32'd0);
        bus = 19'h7FFFF;
        repeat (3) @(negedge clk);
        bus = '0;
        check("R1 disabled out of reset", count, 32'd0);

        // decode table walk (R2, R3, R4, R6)
        for (int i = 0; i < NV; i++) begin
            wr(2'd1, {27'd0, VEC[i][25:21]});
            wr(2'd0, 32'h3);
            bus = VEC[i][20:2];
            @(negedge clk);
            bus = '0;
            check($sformatf("R2/R3/R4/R6 vector %0d", i), count, {30'd0, VEC[i][1:0]});
        end

        // R5 level event held
        wr(2'd1, 32'd2);
        wr(2'd0, 32'h3);
        bus = 19'h00004;
        repeat (5) @(negedge clk);
        bus = '0;
        repeat (2) @(negedge clk);
        check("R5 level event 5 cycles", count, 32'd5);

        // R7 enable off
        wr(2'd0, 32'h0);
        bus = 19'h00004;
        repeat (3) @(negedge clk);
        bus = '0;
        check("R7 disabled hold", count, 32'd5);

        // R8 clear beats increment
        wr(2'd0, 32'h1);
        bus = 19'h00004;
        repeat (2) @(negedge clk);
        check("R8 pre-clear count", count, 32'd7);
        wr_en = 1'b1; wr_addr = 2'd0; wr_data = 32'h3;
        @(negedge clk);
        wr_en = 1'b0; bus = '0;
        check("R8 clear wins over event", count, 32'd0);

        // R9 selector takes effect next cycle
        bus = 19'h00004;
        wr_en = 1'b1; wr_addr = 2'd1; wr_data = 32'd0;
        @(negedge clk);
        wr_en = 1'b0; bus = 19'h00001;
        check("R9 write cycle uses old code", count, 32'd1);
        @(negedge clk);
        bus = '0;
        check("R9 new code next cycle", count, 32'd2);

        // R10 preload beats event
        bus = 19'h00001;
        wr_en = 1'b1; wr_addr = 2'd2; wr_data = 32'h1234;
        @(negedge clk);
        wr_en = 1'b0;
        check("R10 preload wins", count, 32'h1234);
        @(negedge clk);
        bus = '0;
        check("R10 counts after preload", count, 32'h1235);

        // R11 wrap and sticky overflow
        wr(2'd1, 32'd7);
        wr(2'd2, 32'hFFFF_FFFE);
        check("R11 preload leaves ovf clear", {31'd0, ovf}, 32'd0);
        bus = 19'h00300;
        @(negedge clk);
        bus = '0;
        check("R11 +2 from FFFFFFFE", count, 32'd0);
        check("R11 ovf set", {31'd0, ovf}, 32'd1);
        bus = 19'h00100;
        @(negedge clk);
        bus = '0;
        check("R11 ovf sticky", {31'd0, ovf}, 32'd1);
        check("R11 count after wrap", count, 32'd1);
        wr(2'd0, 32'h5);
        check("R11 ovf cleared", {31'd0, ovf}, 32'd0);
        wr(2'd1, 32'd13);
        wr(2'd2, 32'hFFFF_FFFF);
        bus = 19'h08000;
        @(negedge clk);
        bus = '0;
        check("R4/R11 +2 from FFFFFFFF", count, 32'd1);
        check("R11 ovf set again", {31'd0, ovf}, 32'd1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end
endmodule